// File: doc/BRIEF.md
# Residue-Coded Integer ALU

This block performs addition, subtraction and multiplication on integers held in a residue number system built on four pairwise coprime moduli: 5, 7, 9 and 4. Two binary operands are first reduced to one residue digit per modulus. The selected operation is then applied inside each modulus channel on its own. No carry or borrow passes between channels, so every channel has the same short logic depth whatever the word width.

The product of the moduli is 1260, so the four-digit result stands for exactly one integer in 0..1259. A true result outside that range comes back reduced modulo 1260. Subtraction adds the modular complement (m - d) mod m of each subtrahend digit, which leaves a zero digit at zero. The design has two register stages: a conversion stage and a result stage. A valid flag travels alongside the data, and the result register holds its value between operations.

Top module: `rns_alu`

## Requirements
- R1: While rst_n is low, out_valid is 0 and every bit of res_digits is 0.
- R2: With op_sel = 2'b11 (pass), each result digit is op_a mod m for its modulus m, for any 11-bit op_a (0..2047). res_digits packs the digits as: bits [2:0] = mod 5, [5:3] = mod 7, [9:6] = mod 9, [11:10] = mod 4.
- R3: With op_sel = 2'b00 (add), each digit is (op_a + op_b) mod m.
- R4: With op_sel = 2'b01 (subtract), each digit is (op_a - op_b) mod m, taken in the range 0..m-1. A zero subtrahend digit leaves the minuend digit unchanged.
- R5: With op_sel = 2'b10 (multiply), each digit is (op_a * op_b) mod m. A zero digit in either operand gives a zero digit.
- R6: Every result digit is always strictly less than its modulus.
- R7: out_valid is high in exactly those cycles that come two rising edges after a cycle with in_valid high.
- R8: After a cycle in which out_valid is low, res_digits keeps its previous value.
- R9: Results wrap modulo 1260. For example, 1259 + 1 gives all-zero digits, and 0 - 1 gives the digits of 1259.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and op_sel are taken this cycle |
| op_a | input | 11 | First binary operand |
| op_b | input | 11 | Second binary operand |
| op_sel | input | 2 | 00 add, 01 subtract, 10 multiply, 11 pass op_a |
| out_valid | output | 1 | res_digits carries a new result |
| res_digits | output | 12 | Packed residue digits (mod 5, 7, 9, 4 from LSB) |

## Verification
Random operand pairs are run through all four operations. Each channel is compared with the residue of the binary result, and that comparison separates a wrong reduction in one channel from a wrong operation in all of them. Directed cases use zero operands for subtraction and multiplication, which exposes a complement that maps 0 to m. Sums and differences that cross 1260 and 0 show that the channels wrap together. Operand values up to 2047 test the converter beyond the representable range. Idle gaps between valid inputs separate a correct valid delay and hold from a result register that loads every cycle.

// File: rtl/rns_pkg.sv
package rns_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned BIN_W  = 11;
  localparam int unsigned MODS [NUM_CH] = '{5, 7, 9, 4};

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_MUL  = 2'b10,
    OP_PASS = 2'b11
  } rns_op_e;

  function automatic int unsigned digit_w(input int unsigned m);
    return $clog2(m);
  endfunction

  function automatic int unsigned digit_off(input int unsigned ch);
    int unsigned s;
    s = 0;
    for (int unsigned i = 0; i < ch; i++) s += digit_w(MODS[i]);
    return s;
  endfunction

  localparam int unsigned RES_W = digit_off(NUM_CH);
endpackage

// File: rtl/rns_encode.sv
module rns_encode #(
  parameter int unsigned MOD   = 5,
  parameter int unsigned BIN_W = 11,
  localparam int unsigned DW   = $clog2(MOD)
) (
  input  logic [BIN_W-1:0] bin_i,
  output logic [DW-1:0]    dig_o
);
  always_comb begin
    dig_o = DW'(32'(bin_i) % MOD);
  end
endmodule

// File: rtl/rns_lane.sv
module rns_lane
  import rns_pkg::*;
#(
  parameter int unsigned MOD   = 5,
  parameter int unsigned BIN_W = 11,
  localparam int unsigned DW   = $clog2(MOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_in,
  input  logic             ld_res,
  input  logic [BIN_W-1:0] a_bin,
  input  logic [BIN_W-1:0] b_bin,
  input  logic [1:0]       op_in,
  output logic [DW-1:0]    res_o
);
  logic [DW-1:0] a_dig, b_dig;
  logic [DW-1:0] a_q, b_q, a_d, b_d;
  rns_op_e       op_q, op_d;
  logic [DW-1:0] res_q, res_d;

  rns_encode #(.MOD(MOD), .BIN_W(BIN_W)) u_enc_a (.bin_i(a_bin), .dig_o(a_dig));
  rns_encode #(.MOD(MOD), .BIN_W(BIN_W)) u_enc_b (.bin_i(b_bin), .dig_o(b_dig));

  // stage 1 next state: capture converted operands on ld_in
  always_comb begin
    a_d  = a_q;
    b_d  = b_q;
    op_d = op_q;
    if (ld_in) begin
      a_d  = a_dig;
      b_d  = b_dig;
      op_d = rns_op_e'(op_in);
    end
  end

  // stage 2 next state: channel-local arithmetic
  always_comb begin
    int unsigned av, bv, cb, r;
    av = 32'(a_q);
    bv = 32'(b_q);
    cb = (MOD - bv) % MOD;
    case (op_q)
      OP_ADD:  r = (av + bv) % MOD;
      OP_SUB:  r = (av + cb) % MOD;
      OP_MUL:  r = (av * bv) % MOD;
      default: r = av;
    endcase
    res_d = ld_res ? DW'(r) : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      op_q  <= OP_ADD;
      res_q <= '0;
    end else begin
      a_q   <= a_d;
      b_q   <= b_d;
      op_q  <= op_d;
      res_q <= res_d;
    end
  end

  assign res_o = res_q;

  p_digit_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(res_q) < MOD);

  p_add_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_res && op_q == OP_ADD && b_q == '0) |=> res_q == $past(a_q));

  p_sub_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_res && op_q == OP_SUB && b_q == '0) |=> res_q == $past(a_q));

  p_mul_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_res && op_q == OP_MUL && (a_q == '0 || b_q == '0)) |=> res_q == '0);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_res |=> $stable(res_q));
endmodule

// File: rtl/rns_alu.sv
module rns_alu
  import rns_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BIN_W-1:0]  op_a,
  input  logic [BIN_W-1:0]  op_b,
  input  logic [1:0]        op_sel,
  output logic              out_valid,
  output logic [RES_W-1:0]  res_digits
);
  logic v1_q, v1_d, v2_q, v2_d;

  always_comb begin
    v1_d = in_valid;
    v2_d = v1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    localparam int unsigned M   = MODS[g];
    localparam int unsigned W   = digit_w(M);
    localparam int unsigned OFF = digit_off(g);
    rns_lane #(.MOD(M), .BIN_W(BIN_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_in  (in_valid),
      .ld_res (v1_q),
      .a_bin  (op_a),
      .b_bin  (op_b),
      .op_in  (op_sel),
      .res_o  (res_digits[OFF+W-1:OFF])
    );
  end

  assign out_valid = v2_q;

  p_valid_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q |=> out_valid);

  p_valid_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_q |=> !out_valid);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |=> (!out_valid || !$stable(v2_q) || 1'b1) && ($past(v1_q) ? 1'b1 : $stable(res_digits)));
endmodule

// File: tb/rns_alu_test.sv
`timescale 1ns/1ps
module rns_alu_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [10:0] op_a, op_b;
  logic [1:0]  op_sel;
  logic        out_valid;
  logic [11:0] res_digits;

  int total = 0;
  int bad   = 0;
  string cur_tag;

  always #2 clk = ~clk;

  rns_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .op_sel(op_sel), .out_valid(out_valid), .res_digits(res_digits)
  );

  function automatic int unsigned ref_res(int unsigned a, int unsigned b, int unsigned op, int unsigned m);
    case (op)
      0: return (a + b) % m;
      1: return (a + 2520 - b) % m;
      2: return (a * b) % m;
      default: return a % m;
    endcase
  endfunction

  function automatic logic [11:0] ref_pack(int unsigned a, int unsigned b, int unsigned op);
    logic [11:0] p;
    p[2:0]   = 3'(ref_res(a, b, op, 5));
    p[5:3]   = 3'(ref_res(a, b, op, 7));
    p[9:6]   = 4'(ref_res(a, b, op, 9));
    p[11:10] = 2'(ref_res(a, b, op, 4));
    return p;
  endfunction

  // behavioural reference: two-entry delay line plus held result
  logic        m1_v, m2_v;
  logic [11:0] m1_d, m2_d;
  string       m1_t, m2_t;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_v <= 1'b0; m2_v <= 1'b0; m1_d <= '0; m2_d <= '0;
      m1_t <= "R1"; m2_t <= "R1";
    end else begin
      m1_v <= in_valid;
      m2_v <= m1_v;
      if (in_valid) begin
        m1_d <= ref_pack(op_a, op_b, op_sel);
        m1_t <= cur_tag;
      end
      if (m1_v) begin
        m2_d <= m1_d;
        m2_t <= m1_t;
      end
    end
  end

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare every cycle on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R7", {11'd0, out_valid}, {11'd0, m2_v});
      check(m2_v ? m2_t : "R8", res_digits, m2_d);
      total++;
      if (res_digits[2:0] >= 5 || res_digits[5:3] >= 7 || res_digits[9:6] >= 9) begin
        bad++;
        $display("FAIL R6 actual=%h expected=digits below moduli", res_digits);
      end
    end
  end

  task automatic drive(input bit v, input int unsigned a, input int unsigned b,
                       input int unsigned op, input string tag);
    @(negedge clk);
    #0.5;
    in_valid = v; op_a = 11'(a); op_b = 11'(b); op_sel = 2'(op); cur_tag = tag;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; op_sel = '0; cur_tag = "R2";
    repeat (3) @(negedge clk);
    check("R1", {11'd0, out_valid}, 12'd0);
    check("R1", res_digits, 12'd0);
    #0.5 rst_n = 1'b1;
    drive(1, 1259, 1, 0, "R9");
    drive(1, 0, 1, 1, "R9");
    drive(1, 1000, 700, 0, "R9");
    drive(0, 0, 0, 0, "R8");
    drive(1, 2047, 0, 3, "R2");
    drive(1, 1259, 0, 3, "R2");
    drive(1, 123, 0, 1, "R4");
    drive(1, 0, 630, 1, "R4");
    drive(1, 0, 977, 2, "R5");
    drive(1, 35, 36, 2, "R5");
    drive(1, 17, 1242, 0, "R3");
    drive(0, 5, 5, 2, "R8");
    drive(0, 9, 9, 1, "R8");
    for (int i = 0; i < 600; i++) begin
      int unsigned op;
      op = $urandom_range(0, 3);
      drive(($urandom_range(0, 9) < 7), $urandom_range(0, 2047), $urandom_range(0, 2047), op,
            op == 0 ? "R3" : op == 1 ? "R4" : op == 2 ? "R5" : "R2");
    end
    drive(0, 0, 0, 0, "R8");
    repeat (4) @(negedge clk);
    #0.5;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule